// File: doc/BRIEF.md
# Fully Associative Translation Cache with Protection Check

This block caches recent virtual-to-physical page mappings for a 32-bit paged address space. A lookup carries a virtual address, the current address-space ID, the privilege mode (user or supervisor) and the access kind (instruction fetch, load or store). One cycle later the block reports exactly one of three outcomes:
- a hit, with the physical address;
- a protection fault;
- a miss, together with a request to an external hardware page table walker.

The tag compare and the permission check are made in the same cycle. Each entry is either a 4 KiB page or a 4 MiB superpage, and both kinds live in one fully associative array. Entries carry an address-space ID, so a change of user needs no flush. An entry marked global matches under any ID. The walker returns a fill entry. That entry is installed only when the page is resident in memory. A flush command invalidates every entry.

The virtual address splits into three fields: a 10-bit upper page index in bits 31:22, a 10-bit lower page index in bits 21:12, and a 12-bit offset in bits 11:0. The physical page number is 20 bits wide, so the physical address is 32 bits wide.

Top module: `tlb_fa_prot`

## Requirements
- R1: Every cycle with `lk_valid` high produces `rsp_valid` high on the next cycle, with exactly one of `rsp_hit`, `rsp_fault`, `rsp_miss` set. A cycle without a request produces a cycle with all response outputs low.
- R2: A 4 KiB entry matches when its 20-bit page number equals `lk_vaddr[31:12]` and its ID check passes. On a permitted hit, `rsp_paddr` = {entry PPN, `lk_vaddr[11:0]`}.
- R3: A superpage entry (`fill_super`=1) compares only its page number bits [19:10] against `lk_vaddr[31:22]`. On a permitted hit, `rsp_paddr` = {entry PPN[19:10], `lk_vaddr[21:0]`}.
- R4: A non-global entry matches only when its ID equals `lk_asid`. An entry with `fill_global`=1 matches under any `lk_asid`.
- R5: The access codes on `lk_acc` are 0 = fetch, 1 = load, 2 = store; code 3 is treated as a store. A hit on an entry lacking the X bit (fetch), the R bit (load) or the W bit (store) gives `rsp_fault` with `rsp_paddr` = 0.
- R6: When `lk_user`=1, a hit on an entry with U=0 gives `rsp_fault`. When `lk_user`=0, the U bit does not restrict access.
- R7: A miss sets `walk_req` in the same cycle as `rsp_miss`, with `walk_vpn` = the looked-up `lk_vaddr[31:12]` and `walk_asid` = `lk_asid`. Both fields are 0 when `walk_req` is low.
- R8: A fill with `fill_present`=0 installs nothing, so a later lookup of that page still misses.
- R9: `flush` invalidates all entries, and a lookup in any later cycle misses. A fill in the same cycle as `flush` is dropped.
- R10: A fill goes to the lowest-numbered invalid entry. When all entries are valid, it goes to the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, on each such replacement.
- R11: After reset, all entries are invalid and all response and walk outputs are 0.
- R12: A lookup in the same cycle as a fill sees the array as it was before that fill. A lookup in the following cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 9 | Current address-space ID |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 or 3 store |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Permitted translation |
| rsp_fault | output | 1 | Protection fault |
| rsp_miss | output | 1 | No matching entry |
| rsp_paddr | output | 32 | Physical address on hit, else 0 |
| walk_req | output | 1 | Refill request to the page table walker |
| walk_vpn | output | 20 | Page number to walk |
| walk_asid | output | 9 | Address-space ID to walk |
| fill_valid | input | 1 | Fill entry from the walker |
| fill_vpn | input | 20 | Page number of the fill |
| fill_asid | input | 9 | ID of the fill |
| fill_ppn | input | 20 | Physical page number (low 10 bits unused for superpages) |
| fill_present | input | 1 | Page is resident in memory |
| fill_super | input | 1 | 4 MiB superpage |
| fill_global | input | 1 | Match under any ID |
| fill_r | input | 1 | Read permission |
| fill_w | input | 1 | Write permission |
| fill_x | input | 1 | Execute permission |
| fill_u | input | 1 | User access permitted |
| flush | input | 1 | Invalidate all entries |

## Verification
Each lookup result, including the walk request fields, is due on the clock edge after the request. A fill or flush changes what a lookup sees from the cycle after it. The bench drives inputs just after a falling edge. It computes the expected result from its own model as that model stood before the same cycle's fill or flush is applied, and compares the outputs at the next falling edge. A same-cycle fill and lookup, and a same-cycle flush and fill, are driven on purpose so that this ordering is checked at the ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic glb;
    logic sup;
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic perm_ok(perm_t p, logic [1:0] acc, logic user);
    logic kind_ok;
    case (acc_e'(acc))
      ACC_FETCH: kind_ok = p.x;
      ACC_LOAD:  kind_ok = p.r;
      default:   kind_ok = p.w;
    endcase
    return kind_ok && (!user || p.u);
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 9,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [VPN_W-1:0]              w_vpn,
  input  logic [PPN_W-1:0]              w_ppn,
  input  logic [ASID_W-1:0]             w_asid,
  input  tlb_pkg::perm_t                w_perm,
  output logic [N-1:0]                  valid_o,
  output logic [N-1:0][VPN_W-1:0]       vpn_o,
  output logic [N-1:0][PPN_W-1:0]       ppn_o,
  output logic [N-1:0][ASID_W-1:0]      asid_o,
  output tlb_pkg::perm_t [N-1:0]        perm_o
);

  logic [N-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[widx] <= 1'b1;
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [VPN_W-1:0]  vpn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [ASID_W-1:0] asid_q;
    tlb_pkg::perm_t    perm_q;

    always_ff @(posedge clk) begin
      if (we && !flush && widx == IDX_W'(e)) begin
        vpn_q  <= w_vpn;
        ppn_q  <= w_ppn;
        asid_q <= w_asid;
        perm_q <= w_perm;
      end
    end

    assign vpn_o[e]  = vpn_q;
    assign ppn_o[e]  = ppn_q;
    assign asid_o[e] = asid_q;
    assign perm_o[e] = perm_q;
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N      = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic             take,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &valid;
  assign idx  = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && full) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int N      = 32,
  parameter int HI_W   = 10,
  parameter int LO_W   = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 9,
  localparam int VPN_W = HI_W + LO_W,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][PPN_W-1:0]  ppn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  tlb_pkg::perm_t [N-1:0]   perm,
  input  logic [VA_W-1:0]          va,
  input  logic [ASID_W-1:0]        q_asid,
  input  logic                     user,
  input  logic [1:0]               acc,
  output logic                     hit,
  output logic                     allow,
  output logic [PA_W-1:0]          pa
);

  logic [N-1:0]     match;
  logic [PPN_W-1:0] sel_ppn;
  tlb_pkg::perm_t   sel_perm;

  for (genvar e = 0; e < N; e++) begin : g_cmp
    logic id_ok, hi_ok, lo_ok;
    assign id_ok    = perm[e].glb || (asid[e] == q_asid);
    assign hi_ok    = vpn[e][VPN_W-1:LO_W] == va[VA_W-1:OFF_W+LO_W];
    assign lo_ok    = perm[e].sup || (vpn[e][LO_W-1:0] == va[OFF_W+LO_W-1:OFF_W]);
    assign match[e] = valid[e] && id_ok && hi_ok && lo_ok;
  end

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_ppn  = ppn[i];
        sel_perm = perm[i];
      end
    end
  end

  assign hit   = |match;
  assign allow = tlb_pkg::perm_ok(sel_perm, acc, user);
  assign pa    = sel_perm.sup ? {sel_ppn[PPN_W-1:LO_W], va[OFF_W+LO_W-1:0]}
                              : {sel_ppn, va[OFF_W-1:0]};

endmodule

// File: rtl/tlb_fa_prot.sv
module tlb_fa_prot #(
  parameter int N      = 32,
  parameter int HI_W   = 10,
  parameter int LO_W   = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 9,
  localparam int VPN_W = HI_W + LO_W,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_user,
  input  logic [1:0]        lk_acc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0] walk_asid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_present,
  input  logic              fill_super,
  input  logic              fill_global,
  input  logic              fill_r,
  input  logic              fill_w,
  input  logic              fill_x,
  input  logic              fill_u,
  input  logic              flush
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             ent_valid;
  logic [N-1:0][VPN_W-1:0]  ent_vpn;
  logic [N-1:0][PPN_W-1:0]  ent_ppn;
  logic [N-1:0][ASID_W-1:0] ent_asid;
  tlb_pkg::perm_t [N-1:0]   ent_perm;

  logic             install;
  logic [IDX_W-1:0] victim;
  tlb_pkg::perm_t   new_perm;
  logic             lk_hit, lk_allow;
  logic [PA_W-1:0]  lk_pa;

  assign install  = fill_valid && fill_present && !flush;
  assign new_perm = '{glb: fill_global, sup: fill_super, u: fill_u,
                      x: fill_x, w: fill_w, r: fill_r};

  tlb_store #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) i_store (
    .clk(clk), .rst(rst), .flush(flush), .we(install), .widx(victim),
    .w_vpn(fill_vpn), .w_ppn(fill_ppn), .w_asid(fill_asid), .w_perm(new_perm),
    .valid_o(ent_valid), .vpn_o(ent_vpn), .ppn_o(ent_ppn),
    .asid_o(ent_asid), .perm_o(ent_perm)
  );

  tlb_victim #(.N(N)) i_victim (
    .clk(clk), .rst(rst), .valid(ent_valid), .take(install), .idx(victim)
  );

  tlb_lookup #(.N(N), .HI_W(HI_W), .LO_W(LO_W), .OFF_W(OFF_W),
               .PPN_W(PPN_W), .ASID_W(ASID_W)) i_lookup (
    .valid(ent_valid), .vpn(ent_vpn), .ppn(ent_ppn), .asid(ent_asid),
    .perm(ent_perm), .va(lk_vaddr), .q_asid(lk_asid), .user(lk_user),
    .acc(lk_acc), .hit(lk_hit), .allow(lk_allow), .pa(lk_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
      walk_req  <= 1'b0;
      walk_vpn  <= '0;
      walk_asid <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit && lk_allow;
      rsp_fault <= lk_valid && lk_hit && !lk_allow;
      rsp_miss  <= lk_valid && !lk_hit;
      rsp_paddr <= (lk_valid && lk_hit && lk_allow) ? lk_pa : '0;
      walk_req  <= lk_valid && !lk_hit;
      walk_vpn  <= (lk_valid && !lk_hit) ? lk_vaddr[VA_W-1:OFF_W] : '0;
      walk_asid <= (lk_valid && !lk_hit) ? lk_asid : '0;
    end
  end

endmodule

// File: rtl/tlb_fa_prot_chk.sv
module tlb_fa_prot_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             flush,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic             rsp_miss,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_miss || walk_req)); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])); // R2
  AST_PADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0); // R5
  AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> walk_req); // R7
  AST_WALK_ONLY_MISS: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> rsp_miss); // R7
  AST_WALK_VPN: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> walk_vpn == $past(lk_vaddr[VA_W-1:OFF_W])); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_valid |=> rsp_miss); // R9

endmodule

bind tlb_fa_prot tlb_fa_prot_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .VPN_W(VPN_W), .OFF_W(OFF_W)
) i_chk (.*);

// File: tb/test_tlb_fa_prot.sv
module test_tlb_fa_prot;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [8:0]  lk_asid;
  logic        lk_user;
  logic [1:0]  lk_acc;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [8:0]  walk_asid;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [8:0]  fill_asid;
  logic [19:0] fill_ppn;
  logic        fill_present, fill_super, fill_global;
  logic        fill_r, fill_w, fill_x, fill_u;
  logic        flush;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  bit         m_v   [32];
  bit [19:0]  m_vpn [32];
  bit [19:0]  m_ppn [32];
  bit [8:0]   m_asid[32];
  bit         m_sup [32], m_g[32], m_r[32], m_w[32], m_x[32], m_u[32];
  int         m_rr;

  always #10 clk = ~clk;

  tlb_fa_prot i_tlb_fa_prot (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle();
    lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_user = 0; lk_acc = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
    fill_present = 0; fill_super = 0; fill_global = 0;
    fill_r = 0; fill_w = 0; fill_x = 0; fill_u = 0; flush = 0;
  endtask

  // Computes the expected outputs from the model, applies this cycle's
  // fill/flush to the model, waits one cycle and compares.
  task automatic tick(string tag);
    logic [81:0] exp_v, act_v;
    int   found;
    bit   ok;
    logic [31:0] pa;
    found = -1;
    for (int i = 0; i < 32; i++) begin
      if (found < 0 && m_v[i] && (m_g[i] || m_asid[i] == lk_asid) &&
          m_vpn[i][19:10] == lk_vaddr[31:22] &&
          (m_sup[i] || m_vpn[i][9:0] == lk_vaddr[21:12]))
        found = i;
    end
    ok = 0; pa = '0;
    if (found >= 0) begin
      case (lk_acc)
        2'd0: ok = m_x[found];
        2'd1: ok = m_r[found];
        default: ok = m_w[found];
      endcase
      if (lk_user && !m_u[found]) ok = 0;
      if (ok) pa = m_sup[found] ? {m_ppn[found][19:10], lk_vaddr[21:0]}
                                : {m_ppn[found], lk_vaddr[11:0]};
    end
    if (!lk_valid) exp_v = '0;
    else if (found < 0)
      exp_v = {1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 1'b1, lk_vaddr[31:12], lk_asid, 16'h0};
    else
      exp_v = {1'b1, ok, !ok, 1'b0, pa, 1'b0, 20'h0, 9'h0, 16'h0};
    // model update
    if (flush) begin
      for (int i = 0; i < 32; i++) m_v[i] = 0;
    end else if (fill_valid && fill_present) begin
      int slot;
      slot = -1;
      for (int i = 0; i < 32; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % 32;
      end
      m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_ppn[slot] = fill_ppn;
      m_asid[slot] = fill_asid; m_sup[slot] = fill_super; m_g[slot] = fill_global;
      m_r[slot] = fill_r; m_w[slot] = fill_w; m_x[slot] = fill_x; m_u[slot] = fill_u;
    end
    @(negedge clk);
    act_v = {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_paddr,
             walk_req, walk_vpn, walk_asid, 16'h0};
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual v/h/f/m=%b%b%b%b pa=%h walk=%b vpn=%h asid=%h expected %h",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_paddr,
               walk_req, walk_vpn, walk_asid, exp_v[81:16]);
    end
    idle();
  endtask

  task automatic set_fill(logic [19:0] vpn, logic [8:0] asid, logic [19:0] ppn,
                          bit sup, bit g, bit r, bit w, bit x, bit u, bit pres);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
    fill_super = sup; fill_global = g; fill_r = r; fill_w = w; fill_x = x;
    fill_u = u; fill_present = pres;
  endtask

  task automatic set_look(logic [31:0] va, logic [8:0] asid, bit user, logic [1:0] acc);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_user = user; lk_acc = acc;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_v[i] = 0;
    m_rr = 0;
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    tick("R11 reset outputs");
    set_look(32'h1234_5678, 9'd5, 1, 2'd1); tick("R11 empty after reset / R7 walk");

    // R12: lookup in same cycle as fill sees old contents
    set_fill(20'h12345, 9'd5, 20'hABCDE, 0, 0, 1, 1, 1, 1, 1);
    set_look(32'h1234_5678, 9'd5, 1, 2'd1); tick("R12 same-cycle fill invisible");
    set_look(32'h1234_5678, 9'd5, 1, 2'd1); tick("R12 R2 next-cycle hit");
    set_look(32'h1234_5FFF, 9'd5, 1, 2'd0); tick("R2 fetch hit");
    set_look(32'h1234_5000, 9'd5, 0, 2'd2); tick("R2 store hit supervisor");

    // R4 ASID and global
    set_look(32'h1234_5678, 9'd6, 1, 2'd1); tick("R4 other asid misses");
    set_fill(20'h00400, 9'd1, 20'h0F00F, 0, 1, 1, 0, 0, 1, 1); tick("R4 fill global");
    set_look(32'h0040_0ABC, 9'd300, 1, 2'd1); tick("R4 global any asid");
    set_look(32'h0040_0ABC, 9'd1, 1, 2'd1); tick("R4 global own asid");

    // R3 superpage
    set_fill({10'h2A0, 10'h000}, 9'd5, {10'h155, 10'h3FF}, 1, 0, 1, 1, 0, 1, 1); tick("R3 fill super");
    set_look({10'h2A0, 10'h1F3, 12'h456}, 9'd5, 1, 2'd1); tick("R3 super low vpn passes");
    set_look({10'h2A0, 10'h3FF, 12'hFFF}, 9'd5, 1, 2'd2); tick("R3 super top of page");
    set_look({10'h2A1, 10'h1F3, 12'h456}, 9'd5, 1, 2'd1); tick("R3 super other hi misses");

    // R5 permissions: read-only entry
    set_fill(20'h55555, 9'd5, 20'h11111, 0, 0, 1, 0, 0, 1, 1); tick("R5 fill read-only");
    set_look(32'h5555_5010, 9'd5, 1, 2'd2); tick("R5 store to W=0 faults");
    set_look(32'h5555_5010, 9'd5, 1, 2'd3); tick("R5 code 3 as store faults");
    set_look(32'h5555_5010, 9'd5, 1, 2'd0); tick("R5 fetch X=0 faults");
    set_look(32'h5555_5010, 9'd5, 1, 2'd1); tick("R5 read allowed");
    set_fill(20'h66666, 9'd5, 20'h22222, 0, 0, 0, 1, 1, 1, 1); tick("R5 fill no-read");
    set_look(32'h6666_6020, 9'd5, 1, 2'd1); tick("R5 load R=0 faults");
    set_look(32'h6666_6020, 9'd5, 1, 2'd0); tick("R5 fetch X=1 hit");

    // R6 user bit
    set_fill(20'h77777, 9'd5, 20'h33333, 0, 0, 1, 1, 1, 0, 1); tick("R6 fill supervisor page");
    set_look(32'h7777_7004, 9'd5, 1, 2'd1); tick("R6 user on U=0 faults");
    set_look(32'h7777_7004, 9'd5, 0, 2'd1); tick("R6 supervisor on U=0 hit");

    // R8 non-resident fill
    set_fill(20'h88888, 9'd5, 20'h44444, 0, 0, 1, 1, 1, 1, 0); tick("R8 nonresident fill");
    set_look(32'h8888_8000, 9'd5, 1, 2'd1); tick("R8 nonresident still misses");

    // R9 flush
    flush = 1; tick("R9 flush");
    set_look(32'h1234_5678, 9'd5, 1, 2'd1); tick("R9 flushed entry misses");
    set_look(32'h0040_0ABC, 9'd1, 1, 2'd1); tick("R9 flushed global misses");
    flush = 1; set_fill(20'h99999, 9'd5, 20'h55555, 0, 0, 1, 1, 1, 1, 1); tick("R9 flush with fill");
    set_look(32'h9999_9000, 9'd5, 1, 2'd1); tick("R9 fill with flush dropped");

    // R10 replacement
    for (int i = 0; i < 32; i++) begin
      set_fill(20'h01000 + 20'(i), 9'd3, 20'h70000 + 20'(i), 0, 0, 1, 1, 1, 1, 1);
      tick("R10 fill free slot");
    end
    set_look(32'h0101_F000, 9'd3, 1, 2'd1); tick("R10 last slot hit");
    set_fill(20'h02000, 9'd3, 20'h7AAAA, 0, 0, 1, 1, 1, 1, 1); tick("R10 replace slot 0");
    set_look(32'h0100_0000, 9'd3, 1, 2'd1); tick("R10 victim 0 misses");
    set_look(32'h0100_1000, 9'd3, 1, 2'd1); tick("R10 slot 1 kept");
    set_look(32'h0200_0123, 9'd3, 1, 2'd1); tick("R10 new entry hit");
    set_fill(20'h02001, 9'd3, 20'h7BBBB, 0, 0, 1, 1, 1, 1, 1); tick("R10 replace slot 1");
    set_look(32'h0100_1000, 9'd3, 1, 2'd1); tick("R10 victim 1 misses");
    set_look(32'h0100_2000, 9'd3, 1, 2'd1); tick("R10 slot 2 kept");
    set_look(32'h0200_1FFF, 9'd3, 0, 2'd2); tick("R10 second new entry hit");

    // R1 back-to-back and idle gaps
    set_look(32'h0100_3000, 9'd3, 1, 2'd1); tick("R1 back-to-back a");
    set_look(32'h0300_3000, 9'd3, 1, 2'd1); tick("R1 back-to-back b");
    tick("R1 idle after request");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule